// File: doc/BRIEF.md
# Chip-Select Strobe Sequencer

This block drives one bus access to a slow memory or peripheral region. It controls an active-low chip-select, a read strobe and two byte-lane write strobes. A host raises `req_i` for one cycle with a direction, a two-bit lane mask and four 3-bit timing fields, which normally come from the timing register of the selected region. The block then steps through four phases: a setup phase before the strobe, an access phase with the strobe asserted, a hold phase after it, and a recovery phase that keeps chip-select high before the next access can begin. Every phase is counted in clock ticks.

A slow target can stretch the access phase with `wait_i`. This input is asynchronous and passes through a two-flop synchronizer before the sequencer uses it. Read data should be captured during the cycle that `sample_o` is high. `done_o` marks the end of the access. A request that arrives during recovery is stored and starts as soon as recovery is over. A request that arrives at any other busy time is ignored.

Top module: `cs_strobe_seq`

## Requirements
- R1: During reset and after it, `cs_no`, `rd_no`, `wru_no` and `wrl_no` are high, `sample_o` and `done_o` are low, and `ready_o` is high.
- R2: Chip-select goes low in the first cycle after a request is accepted. The strobe goes low after exactly `t_setup_i` cycles of chip-select alone. A value of 0 means both go low in the same cycle.
- R3: Without wait, the strobe stays low for `t_access_i`+1 cycles. A read (`req_write_i`=0) drives `rd_no`. A write drives `wru_no` when `req_lane_i[1]` is 1 and `wrl_no` when `req_lane_i[0]` is 1. The read strobe and the write strobes are never low together.
- R4: When `t_hold_i` is not 0, chip-select stays low for `t_hold_i` cycles after the strobe rises.
- R5: When `t_hold_i` is 0, chip-select rises one cycle before the strobe does. The strobe stays low for exactly one cycle with chip-select high.
- R6: Between two accesses, chip-select stays high for at least 3+`t_recover_i` cycles, where `t_recover_i` is the value captured for the earlier access. The recovery counter never ends early.
- R7: `wait_i` passes through two register stages. Each cycle in which the synchronized level is high freezes the access count, so the strobe is extended by one cycle. Counting resumes on the next cycle after the level drops.
- R8: A request accepted during recovery is stored. Its chip-select goes low in the cycle right after the last recovery cycle.
- R9: `ready_o` is high when the block is idle, or in recovery with nothing stored. A request seen while `ready_o` is low has no effect.
- R10: `sample_o` is high for exactly one cycle per access: the last cycle in which chip-select is low.
- R11: `done_o` is high for one cycle: the first cycle in which chip-select is high after an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one-cycle pulse |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_lane_i | input | 2 | Write lane mask: bit 1 upper, bit 0 lower |
| t_setup_i | input | 3 | Setup ticks |
| t_access_i | input | 3 | Access ticks minus one |
| t_hold_i | input | 3 | Hold ticks, 0 = negative hold |
| t_recover_i | input | 3 | Extra recovery ticks beyond 3 |
| wait_i | input | 1 | Asynchronous stretch request, active high |
| ready_o | output | 1 | Request would be taken this cycle |
| cs_no | output | 1 | Chip-select, active low, registered |
| rd_no | output | 1 | Read strobe, active low, registered |
| wru_no | output | 1 | Upper-lane write strobe, active low, registered |
| wrl_no | output | 1 | Lower-lane write strobe, active low, registered |
| sample_o | output | 1 | Read-data capture cycle |
| done_o | output | 1 | Access finished pulse |

## Verification
The assertions assume that the request fields and the timing fields are stable and valid in any cycle in which `req_i` is high. They also assume that `wait_i` changes at most once per cycle, so the synchronized level is a clean delayed copy of it. The bench drives every input on the falling edge and holds each request for exactly one cycle. It raises `wait_i` only inside an access phase that is long enough to contain the whole stretch. It also sends some requests on purpose while the block is busy, which are not valid requests, to check that they are dropped.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  localparam int TW = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACC,
    PH_HOLD,
    PH_TAIL,
    PH_REC
  } phase_e;

  typedef struct packed {
    logic          wr;
    logic [1:0]    lane;
    logic [TW-1:0] setup;
    logic [TW-1:0] acc;
    logic [TW-1:0] hold;
    logic [TW-1:0] rec;
  } xfer_t;
endpackage

// File: rtl/cs_seq_sync.sv
module cs_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cs_seq_req.sv
module cs_seq_req
  import cs_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  xfer_t attr_i,
  input  logic  idle_i,
  input  logic  drain_i,
  input  logic  rec_last_i,
  output logic  ready_o,
  output logic  start_o,
  output xfer_t start_attr_o
);
  logic  pend_q;
  xfer_t pend_attr_q;
  logic  take;

  assign ready_o      = idle_i | (drain_i & ~pend_q);
  assign take         = req_i & ready_o;
  assign start_o      = (idle_i & req_i) | (rec_last_i & (pend_q | req_i));
  assign start_attr_o = pend_q ? pend_attr_q : attr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_attr_q <= '0;
    end else if (start_o) begin
      pend_q      <= 1'b0;
    end else if (take && drain_i) begin
      pend_q      <= 1'b1;
      pend_attr_q <= attr_i;
    end
  end

  // R8: a stored request exists only while draining
  a_r8_pend_only_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> drain_i);
  // R9: nothing is stored when the block is idle
  a_r9_idle_no_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !pend_q);
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
  import cs_seq_pkg::*;
#(
  parameter int BASE_REC = 3,
  parameter int CW       = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  xfer_t  start_attr_i,
  input  logic   wait_s_i,
  output phase_e phase_d_o,
  output xfer_t  cur_d_o,
  output logic   idle_o,
  output logic   drain_o,
  output logic   rec_last_o,
  output logic   sample_o,
  output logic   done_o
);
  phase_e         phase_q, phase_d;
  xfer_t          cur_q, cur_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           done_q;
  logic           cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cur_d   = cur_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        cur_d = start_attr_i;
        if (start_attr_i.setup != '0) begin
          phase_d = PH_SETUP;
          cnt_d   = CW'(start_attr_i.setup) - CW'(1);
        end else begin
          phase_d = PH_ACC;
          cnt_d   = CW'(start_attr_i.acc);
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_ACC;
          cnt_d   = CW'(cur_q.acc);
        end else cnt_d = cnt_q - CW'(1);
      end
      PH_ACC: if (!wait_s_i) begin
        if (!cnt_zero) cnt_d = cnt_q - CW'(1);
        else if (cur_q.hold == '0) phase_d = PH_TAIL;
        else begin
          phase_d = PH_HOLD;
          cnt_d   = CW'(cur_q.hold) - CW'(1);
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          phase_d = PH_REC;
          cnt_d   = CW'(BASE_REC - 1) + CW'(cur_q.rec);
        end else cnt_d = cnt_q - CW'(1);
      end
      PH_TAIL: begin
        phase_d = PH_REC;
        cnt_d   = CW'(BASE_REC - 2) + CW'(cur_q.rec);
      end
      PH_REC: begin
        if (!cnt_zero) cnt_d = cnt_q - CW'(1);
        else if (start_i) begin
          cur_d = start_attr_i;
          if (start_attr_i.setup != '0) begin
            phase_d = PH_SETUP;
            cnt_d   = CW'(start_attr_i.setup) - CW'(1);
          end else begin
            phase_d = PH_ACC;
            cnt_d   = CW'(start_attr_i.acc);
          end
        end else phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cur_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      cur_q   <= cur_d;
      done_q  <= (phase_d == PH_TAIL) || (phase_q == PH_HOLD && phase_d == PH_REC);
    end
  end

  assign phase_d_o  = phase_d;
  assign cur_d_o    = cur_d;
  assign idle_o     = (phase_q == PH_IDLE);
  assign drain_o    = (phase_q == PH_TAIL) || (phase_q == PH_REC);
  assign rec_last_o = (phase_q == PH_REC) && cnt_zero;
  assign done_o     = done_q;
  // last chip-select-low tick; the wait level decides whether this tick ends the access
  assign sample_o   = (phase_q == PH_ACC && cnt_zero && !wait_s_i && cur_q.hold == '0) ||
                      (phase_q == PH_HOLD && cnt_zero);

  // R7: synchronized wait freezes the access count
  a_r7_wait_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ACC && wait_s_i) |=> (phase_q == PH_ACC && $stable(cnt_q)));
  // R6: recovery is never cut short
  a_r6_rec_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_REC && !cnt_zero) |=> (phase_q == PH_REC));
  // R5: the overhang tick lasts one cycle
  a_r5_tail_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TAIL) |=> (phase_q == PH_REC));
endmodule

// File: rtl/cs_seq_drv.sv
module cs_seq_drv
  import cs_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  phase_e     phase_d_i,
  input  logic       wr_d_i,
  input  logic [1:0] lane_d_i,
  output logic       cs_no,
  output logic       rd_no,
  output logic       wru_no,
  output logic       wrl_no
);
  logic cs_on, stb_on, stb_any;

  assign cs_on  = (phase_d_i == PH_SETUP) || (phase_d_i == PH_ACC) || (phase_d_i == PH_HOLD);
  assign stb_on = (phase_d_i == PH_ACC) || (phase_d_i == PH_TAIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_no  <= 1'b1;
      rd_no  <= 1'b1;
      wru_no <= 1'b1;
      wrl_no <= 1'b1;
    end else begin
      cs_no  <= ~cs_on;
      rd_no  <= ~(stb_on & ~wr_d_i);
      wru_no <= ~(stb_on & wr_d_i & lane_d_i[1]);
      wrl_no <= ~(stb_on & wr_d_i & lane_d_i[0]);
    end
  end

  assign stb_any = ~(rd_no & wru_no & wrl_no);

  // R3: read and write strobes never overlap
  a_r3_dir_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && (!wru_no || !wrl_no)));
  // R5: strobe with chip-select high lasts a single cycle
  a_r5_overhang_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_any && cs_no) |=> !stb_any);
endmodule

// File: rtl/cs_strobe_seq.sv
module cs_strobe_seq
  import cs_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BASE_REC    = 3,
  localparam int CW         = $clog2(BASE_REC + (1 << TW))
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_write_i,
  input  logic [1:0]    req_lane_i,
  input  logic [TW-1:0] t_setup_i,
  input  logic [TW-1:0] t_access_i,
  input  logic [TW-1:0] t_hold_i,
  input  logic [TW-1:0] t_recover_i,
  input  logic          wait_i,
  output logic          ready_o,
  output logic          cs_no,
  output logic          rd_no,
  output logic          wru_no,
  output logic          wrl_no,
  output logic          sample_o,
  output logic          done_o
);
  xfer_t  attr_in, start_attr, cur_d;
  phase_e phase_d;
  logic   wait_s, start, idle, drain, rec_last;

  assign attr_in = '{wr: req_write_i, lane: req_lane_i, setup: t_setup_i,
                     acc: t_access_i, hold: t_hold_i, rec: t_recover_i};

  cs_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(wait_i), .q_o(wait_s)
  );

  cs_seq_req u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .attr_i(attr_in),
    .idle_i(idle), .drain_i(drain), .rec_last_i(rec_last),
    .ready_o(ready_o), .start_o(start), .start_attr_o(start_attr)
  );

  cs_seq_fsm #(.BASE_REC(BASE_REC), .CW(CW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .start_attr_i(start_attr),
    .wait_s_i(wait_s), .phase_d_o(phase_d), .cur_d_o(cur_d), .idle_o(idle),
    .drain_o(drain), .rec_last_o(rec_last), .sample_o(sample_o), .done_o(done_o)
  );

  cs_seq_drv u_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_d_i(phase_d), .wr_d_i(cur_d.wr),
    .lane_d_i(cur_d.lane), .cs_no(cs_no), .rd_no(rd_no), .wru_no(wru_no), .wrl_no(wrl_no)
  );

  // R11: done accompanies every chip-select rise
  a_r11_done_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o);
  // R10: capture pulse only while selected
  a_r10_sample_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !cs_no);
  // R2: chip-select falls only from an accepted request or a running access
  a_r2_cs_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(start));
endmodule

// File: tb/cs_strobe_seq_test.sv
module cs_strobe_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, wt = 1'b0;
  logic [1:0] ln = 2'b00;
  logic [2:0] ts = 3'd0, ta = 3'd0, th = 3'd0, tr = 3'd0;
  logic ready, cs_n, rd_n, wru_n, wrl_n, smp, done;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cs_strobe_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_write_i(wr), .req_lane_i(ln),
    .t_setup_i(ts), .t_access_i(ta), .t_hold_i(th), .t_recover_i(tr), .wait_i(wt),
    .ready_o(ready), .cs_no(cs_n), .rd_no(rd_n), .wru_no(wru_n), .wrl_no(wrl_n),
    .sample_o(smp), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle,1 setup,2 strobe,3 hold,4 overhang,5 recovery
  int m_ph, m_left;
  bit m_pend, m_done, m_ws1, m_ws2, m_wr, p_wr;
  bit [1:0] m_ln, p_ln;
  int m_s, m_a, m_h, m_r, p_s, p_a, p_h, p_r;

  task automatic m_begin();
    if (m_s != 0) begin m_ph = 1; m_left = m_s - 1; end
    else begin m_ph = 2; m_left = m_a; end
  endtask

  task automatic m_load_in();
    m_wr = wr; m_ln = ln; m_s = ts; m_a = ta; m_h = th; m_r = tr;
  endtask

  task automatic m_store();
    m_pend = 1; p_wr = wr; p_ln = ln; p_s = ts; p_a = ta; p_h = th; p_r = tr;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_pend = 0; m_done = 0; m_ws1 = 0; m_ws2 = 0;
      m_wr = 0; m_ln = 0; m_s = 0; m_a = 0; m_h = 0; m_r = 0;
    end else begin
      m_done = 0;
      case (m_ph)
        0: if (req) begin m_load_in(); m_begin(); end
        1: if (m_left == 0) begin m_ph = 2; m_left = m_a; end else m_left--;
        2: if (!m_ws2) begin
             if (m_left != 0) m_left--;
             else if (m_h == 0) begin m_ph = 4; m_done = 1; end
             else begin m_ph = 3; m_left = m_h - 1; end
           end
        3: if (m_left == 0) begin m_ph = 5; m_left = 2 + m_r; m_done = 1; end else m_left--;
        4: begin
             if (req && !m_pend) m_store();
             m_ph = 5; m_left = 1 + m_r;
           end
        default: begin
          if (m_left != 0) begin
            if (req && !m_pend) m_store();
            m_left--;
          end else if (m_pend) begin
            m_pend = 0; m_wr = p_wr; m_ln = p_ln; m_s = p_s; m_a = p_a; m_h = p_h; m_r = p_r;
            m_begin();
          end else if (req) begin m_load_in(); m_begin(); end
          else m_ph = 0;
        end
      endcase
      m_ws2 = m_ws1; m_ws1 = wt;
    end
  end

  // per-cycle comparison and measurement
  bit prev_cs = 1;
  int cs_len, st_len, pre_len, hi_cnt, gap_last, falls, smp_cnt;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit stb, e_cs, e_rd, e_wru, e_wrl, e_smp, e_rdy;
      stb   = (m_ph == 2) || (m_ph == 4);
      e_cs  = !(m_ph == 1 || m_ph == 2 || m_ph == 3);
      e_rd  = !(stb && !m_wr);
      e_wru = !(stb && m_wr && m_ln[1]);
      e_wrl = !(stb && m_wr && m_ln[0]);
      e_smp = (m_ph == 2 && m_left == 0 && !m_ws2 && m_h == 0) || (m_ph == 3 && m_left == 0);
      e_rdy = (m_ph == 0) || ((m_ph == 4 || m_ph == 5) && !m_pend);
      chk(cs_n == e_cs, "R2/R4/R5/R6", "cs_no", cs_n, e_cs);
      chk(rd_n == e_rd, "R3", "rd_no", rd_n, e_rd);
      chk(wru_n == e_wru, "R3", "wru_no", wru_n, e_wru);
      chk(wrl_n == e_wrl, "R3", "wrl_no", wrl_n, e_wrl);
      chk(smp == e_smp, "R10", "sample_o", smp, e_smp);
      chk(done == m_done, "R11", "done_o", done, m_done);
      chk(ready == e_rdy, "R9", "ready_o", ready, e_rdy);

      if (!cs_n && prev_cs) begin
        gap_last = hi_cnt; hi_cnt = 0; cs_len = 0; st_len = 0; pre_len = 0; smp_cnt = 0; falls++;
      end
      if (cs_n) hi_cnt++;
      else begin
        cs_len++;
        if (rd_n && wru_n && wrl_n && st_len == 0) pre_len++;
      end
      if (!(rd_n && wru_n && wrl_n)) st_len++;
      if (smp) smp_cnt++;
      prev_cs = cs_n;
    end
  end

  task automatic issue(input bit w, input bit [1:0] l, input int s, input int a, input int h, input int r);
    @(negedge clk);
    wr = w; ln = l; ts = 3'(s); ta = 3'(a); th = 3'(h); tr = 3'(r); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_ph != 0);
    @(negedge clk);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cs_n && rd_n && wru_n && wrl_n, "R1", "strobes in reset", {cs_n, rd_n, wru_n, wrl_n}, 15);
    chk(!smp && !done && ready, "R1", "sample/done/ready in reset", {smp, done, ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && rd_n && ready, "R1", "after reset release", {cs_n, rd_n, ready}, 7);

    // read, setup 2, access 1, hold 1
    issue(0, 2'b00, 2, 1, 1, 0);
    wait_idle();
    chk(pre_len == 2, "R2", "setup ticks", pre_len, 2);
    chk(st_len == 2, "R3", "read strobe ticks", st_len, 2);
    chk(cs_len == 5, "R4", "cs low ticks", cs_len, 5);
    chk(smp_cnt == 1, "R10", "sample pulses", smp_cnt, 1);

    // upper write, no setup, hold 2
    issue(1, 2'b10, 0, 0, 2, 1);
    wait_idle();
    chk(pre_len == 0, "R2", "zero setup", pre_len, 0);
    chk(st_len == 1, "R3", "upper write ticks", st_len, 1);
    chk(cs_len == 3, "R4", "cs low with hold 2", cs_len, 3);

    // lower write, zero hold
    issue(1, 2'b01, 1, 2, 0, 0);
    wait_idle();
    chk(st_len == 4, "R5", "strobe incl overhang", st_len, 4);
    chk(cs_len == 4, "R5", "cs low with zero hold", cs_len, 4);
    chk(smp_cnt == 1, "R10", "sample pulses zero hold", smp_cnt, 1);

    // wait stretch of three synchronized cycles
    fork
      issue(0, 2'b00, 1, 3, 1, 0);
      begin
        do @(negedge clk); while (rd_n);
        wt = 1'b1;
        repeat (3) @(negedge clk);
        wt = 1'b0;
      end
    join
    wait_idle();
    chk(st_len == 7, "R7", "stretched strobe", st_len, 7);

    // back-to-back: busy request dropped, recovery request held
    begin
      int f0;
      f0 = falls;
      issue(1, 2'b11, 1, 1, 1, 2);
      issue(0, 2'b00, 0, 0, 1, 0);   // lands during access: R9 ignored
      wait_done();
      issue(0, 2'b00, 0, 0, 1, 0);   // lands during recovery: R8 stored
      wait_idle();
      chk(falls - f0 == 2, "R9", "accesses started", falls - f0, 2);
      chk(gap_last == 5, "R8", "gap before stored access", gap_last, 5);
      chk(gap_last >= 5, "R6", "minimum recovery", gap_last, 5);
    end

    // zero hold with base recovery only
    issue(1, 2'b11, 0, 1, 0, 0);
    wait_done();
    issue(1, 2'b01, 2, 0, 1, 0);
    wait_idle();
    chk(gap_last == 3, "R6", "base recovery after zero hold", gap_last, 3);
    chk(pre_len == 2, "R8", "stored access setup", pre_len, 2);

    // request held on the last recovery tick starts directly
    issue(0, 2'b00, 0, 0, 1, 0);
    do @(negedge clk); while (!(m_ph == 5 && m_left == 0));
    wr = 0; ln = 0; ts = 0; ta = 0; th = 1; tr = 0; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_idle();
    chk(gap_last == 3, "R8", "start on last recovery tick", gap_last, 3);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule